// File: doc/BRIEF.md
# Byte and Word Arithmetic-Logic Unit with Nibble Carry

This block is the arithmetic and logic datapath of a small 8-bit processor core. In a single pass it takes an operation code, two operands and the current zero, auxiliary-carry and carry flags. It returns a result, the three flag values to be stored, and one write enable for each flag and for the result. The byte operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare, increment, decrement and four single-bit rotates. The word operations are add, subtract, compare, increment and decrement.

The flag rules are selective, and the write enables carry them out. Increment and decrement keep the carry. Word increment and word decrement touch no flag. Word arithmetic does not write the auxiliary carry: its incoming value is passed through. Rotates change only the carry. Whenever a flag is not written, its output equals the flag that came in, so the register file may also store the flags without looking at the enables.

The outputs are registered: a request presented with `in_valid` high at a rising clock edge is available, with `out_valid` high, right after that edge.

Top module: `bwalu_top`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) produce the byte sum of the low bytes of the operands, with the upper result byte zero. Carry is set on a carry out of bit 7, auxiliary carry on a carry from bit 3 into bit 4, and zero when the result byte is zero. All three flags and the result are written.
- R2: Codes 2 (subtract) and 7 (compare) set carry on a borrow at bit 7, auxiliary carry on a borrow from bit 4 into bit 3, and zero on a zero difference. Compare drives `we_result` low.
- R3: Codes 1 (add with carry) and 3 (subtract with borrow) add or subtract the incoming carry at the least significant bit. Codes 0 and 2 ignore it.
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) write only the zero flag and the result. The carry and auxiliary-carry outputs equal their inputs.
- R5: Codes 8 (word add), 9 (word subtract) and 10 (word compare) work on all 16 operand bits. Carry is taken from bit 15 and zero from the 16-bit result. The auxiliary carry is not written and is passed through. Word compare drives `we_result` low.
- R6: Codes 11 (increment) and 12 (decrement) act on the low byte of operand A. They write the result, zero and auxiliary carry (nibble carry or nibble borrow). The carry is not written and its output equals its input.
- R7: Codes 13 (word increment) and 14 (word decrement) act on all 16 bits of operand A. They write the result and no flag; all flag outputs equal their inputs.
- R8: Codes 15 (rotate right), 16 (rotate left), 17 (rotate right through carry) and 18 (rotate left through carry) rotate the low byte of A by one bit. The plain rotates wrap the moved bit around and copy it into carry. The through-carry rotates fill the vacated bit with the incoming carry and move the shifted-out bit into carry.
- R9: Rotates write neither zero nor auxiliary carry, even when the rotated byte is zero; those outputs equal their inputs.
- R10: Results appear one clock after a request: `out_valid` follows `in_valid` by one cycle. With no request, or with a code from 19 to 31, all write enables are low.
- R11: A synchronous active-low reset clears `out_valid`, the result, the flag outputs and all write enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 5 | Operation code (0 to 18 defined) |
| opnd_a | input | 16 | First operand; byte ops use bits 7:0 |
| opnd_b | input | 16 | Second operand; byte ops use bits 7:0 |
| flag_z_in | input | 1 | Current zero flag |
| flag_ac_in | input | 1 | Current auxiliary-carry flag |
| flag_cy_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result present |
| result | output | 16 | Operation result |
| flag_z_out | output | 1 | Zero flag to store |
| flag_ac_out | output | 1 | Auxiliary-carry flag to store |
| flag_cy_out | output | 1 | Carry flag to store |
| we_z | output | 1 | Zero flag written |
| we_ac | output | 1 | Auxiliary carry written |
| we_cy | output | 1 | Carry flag written |
| we_result | output | 1 | Result written |

## Verification
In a through-carry rotate, the incoming carry is consumed and a new carry is produced in the same cycle, and the two must not be confused. The bench provokes this with an incoming carry that differs from the bit being shifted out. It then checks both that the carry enters the vacated bit and that the flag output holds the outgoing bit. The same cycle-level clash arises when a zero result meets a flag that must stay unchanged, as in a rotate to zero or a word increment that wraps. There the bench sets the incoming zero flag to the opposite of the result's zero state and checks that the output keeps it.

// File: rtl/bwalu_pkg.sv
// Shared types for the byte/word ALU.
// Assumes: operation codes are fixed by the processor decoder; codes above 18 are unused.
package bwalu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_CMP  = 5'd7,
        OP_ADDW = 5'd8,  OP_SUBW = 5'd9,  OP_CMPW = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_INCW = 5'd13, OP_DECW = 5'd14, OP_ROR  = 5'd15,
        OP_ROL  = 5'd16, OP_RORC = 5'd17, OP_ROLC = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic ac;
        logic cy;
    } flags_t;

    typedef struct packed {
        logic z;
        logic ac;
        logic cy;
        logic res;
    } wen_t;
endpackage

// File: rtl/bwalu_byte_arith.sv
// Byte adder/subtractor with nibble carry, shared by add, subtract, compare,
// increment and decrement.
// Assumes: W is even; the nibble boundary is at W/2.
module bwalu_byte_arith
    import bwalu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half
);
    localparam int H = W / 2;

    logic         do_sub;
    logic         c_use;
    logic [W-1:0] y_eff;
    logic [H:0]   lo;
    logic [W:0]   full;

    // Choose the second operand, direction and carry input for this operation.
    always_comb begin
        do_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP) || (op == OP_DEC);
        c_use  = ((op == OP_ADDC) || (op == OP_SUBC)) ? cin : 1'b0;
        y_eff  = ((op == OP_INC) || (op == OP_DEC)) ? W'(1) : y;
    end

    // Compute the low-nibble and full-width sum or difference; the top bit is carry or borrow.
    always_comb begin
        if (do_sub) begin
            lo   = {1'b0, x[H-1:0]} - {1'b0, y_eff[H-1:0]} - (H+1)'(c_use);
            full = {1'b0, x} - {1'b0, y_eff} - (W+1)'(c_use);
        end else begin
            lo   = {1'b0, x[H-1:0]} + {1'b0, y_eff[H-1:0]} + (H+1)'(c_use);
            full = {1'b0, x} + {1'b0, y_eff} + (W+1)'(c_use);
        end
        sum  = full[W-1:0];
        cout = full[W];
        half = lo[H];
    end
endmodule

// File: rtl/bwalu_word_arith.sv
// Word adder/subtractor for word add, subtract, compare, increment and decrement.
// Assumes: no carry input is used by word operations.
module bwalu_word_arith
    import bwalu_pkg::*;
#(
    parameter int WW = 16
) (
    input  alu_op_e       op,
    input  logic [WW-1:0] x,
    input  logic [WW-1:0] y,
    output logic [WW-1:0] sum,
    output logic          cout
);
    logic          do_sub;
    logic [WW-1:0] y_eff;
    logic [WW:0]   full;

    // Select direction and operand, then form the sum with carry or borrow in the top bit.
    always_comb begin
        do_sub = (op == OP_SUBW) || (op == OP_CMPW) || (op == OP_DECW);
        y_eff  = ((op == OP_INCW) || (op == OP_DECW)) ? WW'(1) : y;
        full   = do_sub ? ({1'b0, x} - {1'b0, y_eff}) : ({1'b0, x} + {1'b0, y_eff});
        sum    = full[WW-1:0];
        cout   = full[WW];
    end
endmodule

// File: rtl/bwalu_logic_rot.sv
// Bitwise logic and one-bit rotates on a byte.
// Assumes: rotates use only operand x and the incoming carry.
module bwalu_logic_rot
    import bwalu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    // Form the logic or rotate result and the bit rotated out.
    always_comb begin
        res  = '0;
        cout = cin;
        unique case (op)
            OP_AND:  res = x & y;
            OP_OR:   res = x | y;
            OP_XOR:  res = x ^ y;
            OP_ROR:  begin res = {x[0], x[W-1:1]};   cout = x[0];   end
            OP_ROL:  begin res = {x[W-2:0], x[W-1]}; cout = x[W-1]; end
            OP_RORC: begin res = {cin, x[W-1:1]};    cout = x[0];   end
            OP_ROLC: begin res = {x[W-2:0], cin};    cout = x[W-1]; end
            default: begin res = '0;                 cout = cin;    end
        endcase
    end
endmodule

// File: rtl/bwalu_top.sv
// Byte/word ALU: decodes the operation, selects the unit's result, applies the
// selective flag rules, and registers result, flags and write enables.
// Assumes: flags not written are passed through from the inputs.
module bwalu_top
    import bwalu_pkg::*;
#(
    parameter int BW = 8,
    parameter int WW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic [WW-1:0] opnd_a,
    input  logic [WW-1:0] opnd_b,
    input  logic          flag_z_in,
    input  logic          flag_ac_in,
    input  logic          flag_cy_in,
    output logic          out_valid,
    output logic [WW-1:0] result,
    output logic          flag_z_out,
    output logic          flag_ac_out,
    output logic          flag_cy_out,
    output logic          we_z,
    output logic          we_ac,
    output logic          we_cy,
    output logic          we_result
);
    alu_op_e       op_e;
    logic [BW-1:0] b_sum, l_res;
    logic          b_cy, b_ac, l_cy;
    logic [WW-1:0] w_sum;
    logic          w_cy;
    logic [WW-1:0] nx_res;
    flags_t        nx_flags, flags_q;
    wen_t          nx_wen, wen_q;

    // Interpret the raw opcode bits as an operation.
    always_comb op_e = alu_op_e'(op_code);

    bwalu_byte_arith #(.W(BW)) u_byte (
        .op(op_e), .x(opnd_a[BW-1:0]), .y(opnd_b[BW-1:0]), .cin(flag_cy_in),
        .sum(b_sum), .cout(b_cy), .half(b_ac)
    );

    bwalu_word_arith #(.WW(WW)) u_word (
        .op(op_e), .x(opnd_a), .y(opnd_b), .sum(w_sum), .cout(w_cy)
    );

    bwalu_logic_rot #(.W(BW)) u_lrot (
        .op(op_e), .x(opnd_a[BW-1:0]), .y(opnd_b[BW-1:0]), .cin(flag_cy_in),
        .res(l_res), .cout(l_cy)
    );

    // Select the result and decide which flags are written and with what.
    always_comb begin
        nx_res   = '0;
        nx_flags = '{z: flag_z_in, ac: flag_ac_in, cy: flag_cy_in};
        nx_wen   = '0;
        unique case (op_e)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                nx_res   = WW'(b_sum);
                nx_flags = '{z: (b_sum == '0), ac: b_ac, cy: b_cy};
                nx_wen   = '{z: 1'b1, ac: 1'b1, cy: 1'b1, res: (op_e != OP_CMP)};
            end
            OP_AND, OP_OR, OP_XOR: begin
                nx_res     = WW'(l_res);
                nx_flags.z = (l_res == '0);
                nx_wen     = '{z: 1'b1, ac: 1'b0, cy: 1'b0, res: 1'b1};
            end
            OP_ADDW, OP_SUBW, OP_CMPW: begin
                nx_res      = w_sum;
                nx_flags.z  = (w_sum == '0);
                nx_flags.cy = w_cy;
                nx_wen      = '{z: 1'b1, ac: 1'b0, cy: 1'b1, res: (op_e != OP_CMPW)};
            end
            OP_INC, OP_DEC: begin
                nx_res      = WW'(b_sum);
                nx_flags.z  = (b_sum == '0);
                nx_flags.ac = b_ac;
                nx_wen      = '{z: 1'b1, ac: 1'b1, cy: 1'b0, res: 1'b1};
            end
            OP_INCW, OP_DECW: begin
                nx_res = w_sum;
                nx_wen = '{z: 1'b0, ac: 1'b0, cy: 1'b0, res: 1'b1};
            end
            OP_ROR, OP_ROL, OP_RORC, OP_ROLC: begin
                nx_res      = WW'(l_res);
                nx_flags.cy = l_cy;
                nx_wen      = '{z: 1'b0, ac: 1'b0, cy: 1'b1, res: 1'b1};
            end
            default: begin
                nx_res = '0;
                nx_wen = '0;
            end
        endcase
    end

    // Register the outcome; enables drop when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
            wen_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= nx_res;
                flags_q <= nx_flags;
                wen_q   <= nx_wen;
            end else begin
                wen_q   <= '0;
            end
        end
    end

    // Drive the flag and enable outputs from their registers.
    always_comb begin
        flag_z_out  = flags_q.z;
        flag_ac_out = flags_q.ac;
        flag_cy_out = flags_q.cy;
        we_z        = wen_q.z;
        we_ac       = wen_q.ac;
        we_cy       = wen_q.cy;
        we_result   = wen_q.res;
    end
endmodule

// File: rtl/bwalu_chk.sv
// Protocol and flag-rule checker bound to the ALU top.
// Assumes: in the cycle after reset the past inputs are those held during reset.
module bwalu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  op_code,
    input logic        flag_z_in,
    input logic        flag_ac_in,
    input logic        flag_cy_in,
    input logic        out_valid,
    input logic [15:0] result,
    input logic        flag_z_out,
    input logic        flag_ac_out,
    input logic        flag_cy_out,
    input logic        we_z,
    input logic        we_ac,
    input logic        we_cy,
    input logic        we_result
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(we_z || we_ac || we_cy || we_result));

    // R2
    cmp_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_code) == 5'd7) |-> !we_result);

    // R4
    logic_z_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_code) >= 5'd4 && $past(op_code) <= 5'd6)
        |-> (we_z && !we_ac && !we_cy && flag_cy_out == $past(flag_cy_in)
             && flag_ac_out == $past(flag_ac_in)));

    // R6
    incdec_keep_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(op_code) == 5'd11 || $past(op_code) == 5'd12))
        |-> (!we_cy && flag_cy_out == $past(flag_cy_in)));

    // R7
    word_step_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(op_code) == 5'd13 || $past(op_code) == 5'd14))
        |-> (!we_z && !we_ac && !we_cy && flag_z_out == $past(flag_z_in)));

    // R1
    byte_zero_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_code) <= 5'd3)
        |-> (flag_z_out == (result == 16'h0000)));
endmodule

bind bwalu_top bwalu_chk u_chk (.*);

// File: tb/tb_bwalu_top.sv
module tb_bwalu_top;
    localparam logic [4:0] C_ADD = 0, C_ADDC = 1, C_SUB = 2, C_SUBC = 3, C_AND = 4,
        C_OR = 5, C_XOR = 6, C_CMP = 7, C_ADDW = 8, C_SUBW = 9, C_CMPW = 10,
        C_INC = 11, C_DEC = 12, C_INCW = 13, C_DECW = 14, C_ROR = 15, C_ROL = 16,
        C_RORC = 17, C_ROLC = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        flag_z_in = 1'b0, flag_ac_in = 1'b0, flag_cy_in = 1'b0;
    logic        out_valid;
    logic [15:0] result;
    logic        flag_z_out, flag_ac_out, flag_cy_out;
    logic        we_z, we_ac, we_cy, we_result;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    bwalu_top dut (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one request at a falling edge; outputs are valid just after the next rising edge.
    task automatic apply(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic z, input logic ac, input logic cy);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        flag_z_in = z; flag_ac_in = ac; flag_cy_in = cy;
        @(posedge clk); #1;
    endtask

    // Check result, flags {z,ac,cy} and enables {z,ac,cy,res} together.
    task automatic expect_out(input string tag, input logic [15:0] r, input logic [2:0] f,
                              input logic [3:0] w);
        chk({tag, " result"}, result, r);
        chk({tag, " flags"}, 16'({flag_z_out, flag_ac_out, flag_cy_out}), 16'(f));
        chk({tag, " enables"}, 16'({we_z, we_ac, we_cy, we_result}), 16'(w));
    endtask

    task automatic t_reset();
        repeat (2) @(posedge clk);
        #1;
        chk("R11 reset valid", 16'(out_valid), 16'd0);
        expect_out("R11 reset", 16'h0000, 3'b000, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_add();
        apply(C_ADD, 16'hAB0F, 16'hCD01, 1, 0, 1);
        expect_out("R1 add nibble carry", 16'h0010, 3'b010, 4'b1111);
        chk("R10 valid after one cycle", 16'(out_valid), 16'd1);
        apply(C_ADD, 16'h00F0, 16'h0010, 0, 1, 0);
        expect_out("R1 add carry out zero", 16'h0000, 3'b101, 4'b1111);
        apply(C_ADD, 16'h0012, 16'h0034, 1, 1, 1);
        expect_out("R3 add ignores carry", 16'h0046, 3'b000, 4'b1111);
    endtask

    task automatic t_sub();
        apply(C_SUB, 16'h0010, 16'h0001, 1, 0, 1);
        expect_out("R2 sub nibble borrow", 16'h000F, 3'b010, 4'b1111);
        apply(C_SUB, 16'h0000, 16'h0001, 1, 0, 0);
        expect_out("R2 sub borrow", 16'h00FF, 3'b011, 4'b1111);
        apply(C_SUB, 16'h0055, 16'h0055, 0, 1, 1);
        expect_out("R2 sub zero", 16'h0000, 3'b100, 4'b1111);
        apply(C_CMP, 16'h0020, 16'h0030, 1, 1, 0);
        chk("R2 cmp flags", 16'({flag_z_out, flag_ac_out, flag_cy_out}), 16'b001);
        chk("R2 cmp no result write", 16'(we_result), 16'd0);
    endtask

    task automatic t_carry_in();
        apply(C_ADDC, 16'h00FF, 16'h0000, 0, 0, 1);
        expect_out("R3 addc carry in", 16'h0000, 3'b111, 4'b1111);
        apply(C_SUBC, 16'h0010, 16'h000F, 0, 0, 1);
        expect_out("R3 subc borrow in", 16'h0000, 3'b110, 4'b1111);
        apply(C_ADDC, 16'h0001, 16'h0001, 1, 1, 0);
        expect_out("R3 addc no carry", 16'h0002, 3'b000, 4'b1111);
    endtask

    task automatic t_logic();
        apply(C_AND, 16'h00F0, 16'h000F, 0, 1, 1);
        expect_out("R4 and zero", 16'h0000, 3'b111, 4'b1001);
        apply(C_OR, 16'h00A0, 16'h0005, 1, 0, 0);
        expect_out("R4 or", 16'h00A5, 3'b000, 4'b1001);
        apply(C_XOR, 16'h005A, 16'h005A, 0, 0, 1);
        expect_out("R4 xor zero", 16'h0000, 3'b101, 4'b1001);
    endtask

    task automatic t_word();
        apply(C_ADDW, 16'hFFFF, 16'h0001, 0, 1, 0);
        expect_out("R5 addw wrap", 16'h0000, 3'b111, 4'b1011);
        apply(C_SUBW, 16'h1000, 16'h0001, 1, 0, 1);
        expect_out("R5 subw", 16'h0FFF, 3'b000, 4'b1011);
        apply(C_CMPW, 16'h1234, 16'h1235, 1, 1, 0);
        chk("R5 cmpw flags", 16'({flag_z_out, flag_ac_out, flag_cy_out}), 16'b011);
        chk("R5 cmpw enables", 16'({we_z, we_ac, we_cy, we_result}), 16'b1010);
    endtask

    task automatic t_incdec();
        apply(C_INC, 16'h000F, 16'h0000, 1, 0, 1);
        expect_out("R6 inc nibble", 16'h0010, 3'b011, 4'b1101);
        apply(C_INC, 16'h00FF, 16'h0000, 0, 0, 0);
        expect_out("R6 inc wrap keeps cy", 16'h0000, 3'b110, 4'b1101);
        apply(C_DEC, 16'h0010, 16'h0000, 1, 0, 1);
        expect_out("R6 dec nibble borrow", 16'h000F, 3'b011, 4'b1101);
        apply(C_DEC, 16'h0001, 16'h0000, 0, 1, 0);
        expect_out("R6 dec zero", 16'h0000, 3'b100, 4'b1101);
    endtask

    task automatic t_word_step();
        apply(C_INCW, 16'hFFFF, 16'h0000, 0, 1, 0);
        expect_out("R7 incw no flags", 16'h0000, 3'b010, 4'b0001);
        apply(C_DECW, 16'h0000, 16'h0000, 1, 0, 1);
        expect_out("R7 decw no flags", 16'hFFFF, 3'b101, 4'b0001);
    endtask

    task automatic t_rotate();
        apply(C_ROR, 16'h0081, 16'h0000, 0, 0, 0);
        expect_out("R8 ror", 16'h00C0, 3'b001, 4'b0011);
        apply(C_ROL, 16'h0081, 16'h0000, 1, 1, 0);
        expect_out("R8 rol", 16'h0003, 3'b111, 4'b0011);
        apply(C_RORC, 16'h0002, 16'h0000, 0, 0, 1);
        expect_out("R8 rorc", 16'h0081, 3'b000, 4'b0011);
        apply(C_ROLC, 16'h0080, 16'h0000, 0, 1, 0);
        expect_out("R9 rolc zero keeps z", 16'h0000, 3'b011, 4'b0011);
    endtask

    task automatic t_idle();
        apply(5'd19, 16'h1234, 16'h5678, 1, 0, 1);
        expect_out("R10 unknown code", 16'h0000, 3'b101, 4'b0000);
        @(negedge clk); in_valid = 1'b0; op_code = C_ADD;
        @(posedge clk); #1;
        chk("R10 idle valid", 16'(out_valid), 16'd0);
        chk("R10 idle enables", 16'({we_z, we_ac, we_cy, we_result}), 16'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_add();
                t_sub();
                t_carry_in();
                t_logic();
                t_word();
                t_incdec();
                t_word_step();
                t_rotate();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule